// File: doc/BRIEF.md
# Idle-Gap LFPS Burst Detector

This block recognises low-frequency periodic signalling bursts on a serial lane without ever looking at the square wave. It watches only the lane's electrical-idle (loss-of-signal) flag. Any interval where that flag is low, with idle on both sides, is taken to be one burst. The block measures how long the non-idle interval lasts and how much idle time came before it.

The idle flag is known to drop in and out while a burst is in progress. For this reason, a run of idle shorter than a programmable count is absorbed into the burst that surrounds it. Each accepted burst is sorted into ping, polling or out-of-range using two programmable length windows. The result is presented on a single-cycle strobe. A non-idle stretch longer than a programmable limit is not reported as a burst; it raises a separate one-cycle flag instead.

Top module: `lfps_gap_detector`

## Requirements
- R1: `idle_in` passes through a two-flop synchronizer that resets to idle. After a burst, the result strobe rises exactly `cfg_glitch_min`+2 clock cycles after the cycle in which `idle_in` was driven high.
- R2: The reported burst length `res_burst` equals the number of clock cycles from the first non-idle cycle to the last non-idle cycle of the interval.
- R3: A run of idle shorter than `cfg_glitch_min` cycles inside a burst does not end it. Its cycles count toward the burst length.
- R4: A run of `cfg_glitch_min` consecutive idle cycles ends the burst (a value of 0 acts as 1). Non-idle activity after that run starts a new burst with its own result.
- R5: A burst whose length exceeds `cfg_burst_max` produces a one-cycle `not_lfps` pulse when it ends, and no result strobe. A burst of exactly `cfg_burst_max` is reported normally.
- R6: `res_gap` equals the number of idle cycles between the last non-idle cycle of the previous interval (reported or not) and the first non-idle cycle of this burst.
- R7: The value of `res_class` is assigned as follows:
  - 0 (ping) when `res_burst` lies within [`cfg_ping_min`, `cfg_ping_max`];
  - otherwise 1 (polling) when it lies within [`cfg_poll_min`, `cfg_poll_max`];
  - otherwise 2 (out of range).
- R8: `res_valid` and `not_lfps` are each high for one cycle per interval, and they are never high together.
- R9: All length and gap counters saturate at 2^CW-1 instead of wrapping.
- R10: While `rst_n` is low and after it is released, `res_valid` and `not_lfps` are low and the lane counts as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_in | input | 1 | Electrical-idle flag from the lane, asynchronous |
| cfg_glitch_min | input | CW | Idle cycles needed to end a burst |
| cfg_burst_max | input | CW | Longest burst accepted as LFPS |
| cfg_ping_min | input | CW | Ping window lower bound |
| cfg_ping_max | input | CW | Ping window upper bound |
| cfg_poll_min | input | CW | Polling window lower bound |
| cfg_poll_max | input | CW | Polling window upper bound |
| res_valid | output | 1 | One-cycle result strobe |
| res_burst | output | CW | Measured burst length in cycles |
| res_gap | output | CW | Idle cycles before this burst |
| res_class | output | 2 | 0 ping, 1 polling, 2 out of range |
| not_lfps | output | 1 | One-cycle flag for an over-long interval |

## Verification
Two decisions fall in the same cycle: confirming that the burst has ended, and judging whether it was too long. Both are made on the clock edge where the `cfg_glitch_min`-th idle cycle is seen, and they select which of the two strobes fires. The bench provokes this edge with bursts of exactly `cfg_burst_max` cycles and of one cycle more. It judges the outcome by requiring `res_valid` with the full length in the first case, and only `not_lfps` in the second. A related boundary is an idle run of `cfg_glitch_min`-1 cycles against one of exactly `cfg_glitch_min` cycles. The bench checks this boundary by the number of results and by their lengths.

// File: rtl/lfps_gap_detector.sv
module lfps_gap_detector #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle_in,
  input  logic [CW-1:0] cfg_glitch_min,
  input  logic [CW-1:0] cfg_burst_max,
  input  logic [CW-1:0] cfg_ping_min,
  input  logic [CW-1:0] cfg_ping_max,
  input  logic [CW-1:0] cfg_poll_min,
  input  logic [CW-1:0] cfg_poll_max,
  output logic          res_valid,
  output logic [CW-1:0] res_burst,
  output logic [CW-1:0] res_gap,
  output logic [1:0]    res_class,
  output logic          not_lfps
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          sync1, idle_s;
  logic          in_burst, long_f;
  logic [CW-1:0] gap_cnt, span, mark, glc, prev_gap;

  wire [CW-1:0] span_n = (span == CMAX) ? span : span + ONE;
  wire [CW-1:0] glc_n  = (glc == CMAX) ? glc : glc + ONE;
  wire [CW-1:0] gap_n  = (gap_cnt == CMAX) ? gap_cnt : gap_cnt + ONE;
  wire          ends   = in_burst && idle_s && (glc_n >= cfg_glitch_min);

  wire is_ping = (mark >= cfg_ping_min) && (mark <= cfg_ping_max);
  wire is_poll = (mark >= cfg_poll_min) && (mark <= cfg_poll_max);
  wire [1:0] cls = is_ping ? 2'd0 : (is_poll ? 2'd1 : 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= 1'b1;
      idle_s <= 1'b1;
    end else begin
      sync1  <= idle_in;
      idle_s <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_burst  <= 1'b0;
      long_f    <= 1'b0;
      gap_cnt   <= '0;
      span      <= '0;
      mark      <= '0;
      glc       <= '0;
      prev_gap  <= '0;
      res_valid <= 1'b0;
      not_lfps  <= 1'b0;
      res_burst <= '0;
      res_gap   <= '0;
      res_class <= 2'd0;
    end else begin
      res_valid <= 1'b0;
      not_lfps  <= 1'b0;
      if (!in_burst) begin
        if (idle_s) begin
          gap_cnt <= gap_n;
        end else begin
          in_burst <= 1'b1;
          prev_gap <= gap_cnt;
          span     <= ONE;
          mark     <= ONE;
          glc      <= '0;
          long_f   <= (cfg_burst_max == '0);
        end
      end else begin
        span <= span_n;
        if (!idle_s) begin
          glc  <= '0;
          mark <= span_n;
          if (span_n > cfg_burst_max) long_f <= 1'b1;
        end else if (ends) begin
          in_burst <= 1'b0;
          gap_cnt  <= glc_n;
          if (long_f) begin
            not_lfps <= 1'b1;
          end else begin
            res_valid <= 1'b1;
            res_burst <= mark;
            res_gap   <= prev_gap;
            res_class <= cls;
          end
        end else begin
          glc <= glc_n;
        end
      end
    end
  end
endmodule

module lfps_gap_detector_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cfg_burst_max,
  input logic [CW-1:0] cfg_ping_min,
  input logic [CW-1:0] cfg_ping_max,
  input logic          res_valid,
  input logic [CW-1:0] res_burst,
  input logic [1:0]    res_class,
  input logic          not_lfps
);
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && not_lfps));
  p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  p_single_long_r8: assert property (@(posedge clk) disable iff (!rst_n)
    not_lfps |=> !not_lfps);
  p_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_burst <= cfg_burst_max);
  p_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_burst != '0);
  p_ping_win_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_class == 2'd0) |-> (res_burst >= cfg_ping_min && res_burst <= cfg_ping_max));
  p_class_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_class != 2'd3);
endmodule

bind lfps_gap_detector lfps_gap_detector_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_burst_max(cfg_burst_max),
  .cfg_ping_min(cfg_ping_min), .cfg_ping_max(cfg_ping_max),
  .res_valid(res_valid), .res_burst(res_burst), .res_class(res_class),
  .not_lfps(not_lfps)
);

// File: tb/lfps_gap_detector_bench.sv
module lfps_gap_detector_bench;
  localparam int CW = 8;
  localparam int G  = 4;
  localparam int TAIL = 10;
  // D, L1, g, L2, expected burst, expected class
  localparam int VEC [8][6] = '{
    '{30,  5, 0, 0,  5, 0},
    '{50, 25, 0, 0, 25, 1},
    '{12, 10, 2, 8, 20, 1},
    '{20, 14, 0, 0, 14, 2},
    '{25, 60, 0, 0, 60, 2},
    '{25,  2, 0, 0,  2, 0},
    '{25, 40, 0, 0, 40, 1},
    '{30,  8, 3, 9, 20, 1}
  };

  logic clk = 1'b0, rst_n = 1'b0, idle_in = 1'b1;
  logic [CW-1:0] g_min = CW'(G), b_max = CW'(60);
  logic [CW-1:0] p_lo = CW'(2), p_hi = CW'(10), q_lo = CW'(20), q_hi = CW'(40);
  logic res_valid, not_lfps;
  logic [CW-1:0] res_burst, res_gap;
  logic [1:0] res_class;

  int tests = 0, fails = 0, cyc = 0;
  int ev = 0, nl = 0, last_cyc = 0;
  int rb [256], rg [256], rc [256];
  logic prev_rv = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lfps_gap_detector #(.CW(CW)) u_lfps_gap_detector (
    .clk(clk), .rst_n(rst_n), .idle_in(idle_in),
    .cfg_glitch_min(g_min), .cfg_burst_max(b_max),
    .cfg_ping_min(p_lo), .cfg_ping_max(p_hi),
    .cfg_poll_min(q_lo), .cfg_poll_max(q_hi),
    .res_valid(res_valid), .res_burst(res_burst), .res_gap(res_gap),
    .res_class(res_class), .not_lfps(not_lfps)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid && not_lfps) check("R8 both strobes", 1, 0);
      if (res_valid && prev_rv) check("R8 strobe width", 2, 1);
      if (res_valid) begin
        rb[ev % 256] = int'(res_burst);
        rg[ev % 256] = int'(res_gap);
        rc[ev % 256] = int'(res_class);
        ev++;
        last_cyc = cyc;
      end
      if (not_lfps) nl++;
      prev_rv = res_valid;
    end
  end

  task automatic idle_run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      idle_in = 1'b1;
    end
  endtask

  task automatic act_run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      idle_in = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int e0, n0, t0;
    repeat (3) @(negedge clk);
    check("R10 res_valid in reset", int'(res_valid), 0);
    check("R10 not_lfps in reset", int'(not_lfps), 0);
    rst_n = 1'b1;
    idle_run(20);
    check("R10 no strobe after reset", ev + nl, 0);

    act_run(5);
    @(negedge clk);
    idle_in = 1'b1;
    t0 = cyc;
    idle_run(TAIL - 1);
    check("R1 strobe latency", last_cyc - t0, G + 2);

    for (int v = 0; v < 8; v++) begin
      e0 = ev;
      idle_run(VEC[v][0]);
      act_run(VEC[v][1]);
      if (VEC[v][2] > 0) begin
        idle_run(VEC[v][2]);
        act_run(VEC[v][3]);
      end
      idle_run(TAIL);
      check("R3 R4 one result per vector", ev - e0, 1);
      check("R2 R3 burst length", rb[(ev - 1) % 256], VEC[v][4]);
      check("R6 gap length", rg[(ev - 1) % 256], VEC[v][0] + TAIL);
      check("R7 class code", rc[(ev - 1) % 256], VEC[v][5]);
    end

    e0 = ev;
    act_run(5);
    idle_run(G);
    act_run(6);
    idle_run(TAIL);
    check("R4 exact glitch_min splits", ev - e0, 2);
    check("R4 first part length", rb[e0 % 256], 5);
    check("R4 second part length", rb[(e0 + 1) % 256], 6);
    check("R6 gap equals split run", rg[(e0 + 1) % 256], G);

    e0 = ev;
    n0 = nl;
    act_run(61);
    idle_run(TAIL);
    check("R5 over-long gives no result", ev - e0, 0);
    check("R5 over-long flagged once", nl - n0, 1);
    act_run(5);
    idle_run(TAIL);
    check("R6 gap after over-long", rg[(ev - 1) % 256], TAIL);
    check("R5 normal after over-long", rb[(ev - 1) % 256], 5);

    b_max = CW'(255);
    idle_run(300);
    act_run(300);
    idle_run(TAIL);
    check("R9 burst saturates", rb[(ev - 1) % 256], 255);
    check("R9 gap saturates", rg[(ev - 1) % 256], 255);
    check("R9 R7 saturated class", rc[(ev - 1) % 256], 2);
    b_max = CW'(60);

    g_min = '0;
    e0 = ev;
    act_run(3);
    idle_run(1);
    act_run(3);
    idle_run(TAIL);
    check("R4 zero glitch_min acts as one", ev - e0, 2);
    g_min = CW'(G);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule